// File: doc/BRIEF.md
# Flash Security ID Command Controller

This block decodes the write-command stream of a parallel NOR flash device for everything to do with its 256-bit security identifier. A host issues word writes (address, data, write strobe). The block recognises unlock prefixes and can do four things. It can switch into a query mode where the identifier can be read. It can leave that mode. It can program one word of the user half of the identifier. It can permanently lock that user half.

The identifier has two halves of eight 16-bit words each. The factory half is a fixed parameter and can never change. The user half starts with every bit set. A word program can only clear bits. No command of any kind can erase either half.

While a word program runs, the block ignores all writes. During that time a read returns a status word whose only live bit flips on every read. When the program time has elapsed, reads return data again.

Top module: `secid_cmd_ctrl`

## Requirements
- R1: After reset the block is in normal read mode. `busy` is 0, `rdata` is FFFFh, the user half is unlocked and every user word holds FFFFh.
- R2: Three writes enter query mode: AAh to 5555h, then 55h to 2AAAh, then 88h to 5555h (only the low data byte is compared). In query mode a read at word address i (0 to 7) returns bits [16i+15:16i] of the factory identifier.
- R3: In query mode a read at address 10h to 17h returns user word (address − 10h). Every other address returns FFFFh. In normal read mode every read returns FFFFh. Read data appears on `rdata` on the clock edge that samples `rd_en` and is held until the next read.
- R4: Query mode is left in either of two ways. One is the two-write prefix followed by F0h at 5555h. The other is a single write of F0h to any address when no sequence is in progress.
- R5: A write that does not match the next expected step of a sequence abandons that sequence. The next write is then decoded from the start.
- R6: The prefix followed by A5h at 5555h arms a word program. The next write, to address 10h to 17h, sets that user word to (old AND data) once the program time has elapsed. An armed write to any other address, including the factory addresses 0 to 7, changes nothing and does not start a program.
- R7: `busy` rises on the edge that takes an accepted program data write. It stays high for exactly PROG_CYCLES clock cycles.
- R8: A read while `busy` is high returns a status word in which every bit except bit 6 is 0. Bit 6 alternates between successive reads. Bit 7 never carries data-polling information.
- R9: Every write made while `busy` is high is ignored. This includes the single-write F0h exit, so the mode does not change.
- R10: The prefix followed by 85h at 5555h locks the user half permanently. After that, armed program writes start no program and leave the user words unchanged.
- R11: Any other third command byte, and any erase-style sequence, leaves both halves unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data or status word |
| busy | output | 1 | High while a word program is running |

## Verification
The hardest situation to reach from the ports is a command that arrives while a program is running. The stimulus gets there by entering query mode and starting a program. It then issues status reads and a single-write exit inside the busy window. Afterwards it reads a factory word to show that the mode survived, and it counts the busy cycles against PROG_CYCLES. The lock tests need the same kind of setup: a lock sequence followed by armed program writes. The bench proves that no busy window opens and that the word keeps its value.

// File: rtl/secid_pkg.sv
package secid_pkg;
    localparam int WORD_W     = 16;
    localparam int SEG_WORDS  = 8;
    localparam int IDX_W      = $clog2(SEG_WORDS);
    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [7:0]  OP_QUERY   = 8'h88;
    localparam logic [7:0]  OP_LEAVE   = 8'hF0;
    localparam logic [7:0]  OP_PROGRAM = 8'hA5;
    localparam logic [7:0]  OP_LOCK    = 8'h85;
    localparam logic [12:0] USER_BASE  = 13'd2;   // word addresses 10h..17h
    localparam logic [12:0] FACT_BASE  = 13'd0;   // word addresses 00h..07h

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_ARMED
    } seq_state_e;
endpackage

// File: rtl/secid_decode.sv
module secid_decode
    import secid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output logic              query_mode,
    output logic              locked,
    output logic              pgm_go,
    output logic [IDX_W-1:0]  pgm_idx,
    output logic [WORD_W-1:0] pgm_data
);
    typedef struct packed {
        seq_state_e st;
        logic       query;
        logic       lock;
    } dec_t;

    dec_t s_d, s_q;
    logic [7:0] op;

    assign op = wdata[7:0];

    always_comb begin
        s_d      = s_q;
        pgm_go   = 1'b0;
        pgm_idx  = addr[IDX_W-1:0];
        pgm_data = wdata;
        if (wr_en && !busy) begin
            unique case (s_q.st)
                SQ_IDLE: begin
                    if (addr == UNLOCK_ADDR_A && op == KEY_A) begin
                        s_d.st = SQ_KEY1;
                    end else if (op == OP_LEAVE) begin
                        s_d.query = 1'b0;
                    end
                end
                SQ_KEY1: begin
                    s_d.st = (addr == UNLOCK_ADDR_B && op == KEY_B) ? SQ_KEY2 : SQ_IDLE;
                end
                SQ_KEY2: begin
                    s_d.st = SQ_IDLE;
                    if (addr == UNLOCK_ADDR_A) begin
                        case (op)
                            OP_QUERY:   s_d.query = 1'b1;
                            OP_LEAVE:   s_d.query = 1'b0;
                            OP_PROGRAM: s_d.st    = SQ_ARMED;
                            OP_LOCK:    s_d.lock  = 1'b1;
                            default:    s_d.st    = SQ_IDLE;
                        endcase
                    end
                end
                SQ_ARMED: begin
                    s_d.st = SQ_IDLE;
                    if (!s_q.lock && addr[15:IDX_W] == USER_BASE) begin
                        pgm_go = 1'b1;
                    end
                end
                default: s_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, query: 1'b0, lock: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign query_mode = s_q.query;
    assign locked     = s_q.lock;
endmodule

// File: rtl/secid_pgm_timer.sv
module secid_pgm_timer #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_go,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (pgm_go) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/secid_store.sv
module secid_store
    import secid_pkg::*;
#(
    parameter logic [SEG_WORDS*WORD_W-1:0] FACTORY_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [15:0]       addr,
    input  logic              query_mode,
    input  logic              busy,
    input  logic              pgm_go,
    input  logic [IDX_W-1:0]  pgm_idx,
    input  logic [WORD_W-1:0] pgm_data,
    input  logic              done,
    output logic [WORD_W-1:0] rdata
);
    localparam int TOG_BIT = 6;

    typedef struct packed {
        logic [SEG_WORDS-1:0][WORD_W-1:0] user;
        logic [IDX_W-1:0]                 idx;
        logic [WORD_W-1:0]                mask;
        logic                             tog;
        logic [WORD_W-1:0]                rd;
    } st_t;

    st_t s_d, s_q;
    logic [SEG_WORDS-1:0][WORD_W-1:0] fact_words;

    generate
        for (genvar g = 0; g < SEG_WORDS; g++) begin : g_fact
            assign fact_words[g] = FACTORY_ID[g*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (pgm_go) begin
            s_d.idx  = pgm_idx;
            s_d.mask = pgm_data;
        end
        if (done) begin
            s_d.user[s_q.idx] = s_q.user[s_q.idx] & s_q.mask;
        end
        if (rd_en) begin
            if (busy) begin
                s_d.tog         = ~s_q.tog;
                s_d.rd          = '0;
                s_d.rd[TOG_BIT] = ~s_q.tog;
            end else if (!query_mode) begin
                s_d.rd = '1;
            end else if (addr[15:IDX_W] == FACT_BASE) begin
                s_d.rd = fact_words[addr[IDX_W-1:0]];
            end else if (addr[15:IDX_W] == USER_BASE) begin
                s_d.rd = s_q.user[addr[IDX_W-1:0]];
            end else begin
                s_d.rd = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{user: '1, idx: '0, mask: '1, tog: 1'b0, rd: '1};
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rd;
endmodule

// File: rtl/secid_cmd_ctrl.sv
module secid_cmd_ctrl
    import secid_pkg::*;
#(
    parameter int PROG_CYCLES = 20,
    parameter logic [SEG_WORDS*WORD_W-1:0] FACTORY_ID =
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        busy
);
    logic              query_mode;
    logic              locked;
    logic              pgm_go;
    logic [IDX_W-1:0]  pgm_idx;
    logic [WORD_W-1:0] pgm_data;
    logic              done;

    secid_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .busy       (busy),
        .query_mode (query_mode),
        .locked     (locked),
        .pgm_go     (pgm_go),
        .pgm_idx    (pgm_idx),
        .pgm_data   (pgm_data)
    );

    secid_pgm_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pgm_go (pgm_go),
        .busy   (busy),
        .done   (done)
    );

    secid_store #(.FACTORY_ID(FACTORY_ID)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .addr       (addr),
        .query_mode (query_mode),
        .busy       (busy),
        .pgm_go     (pgm_go),
        .pgm_idx    (pgm_idx),
        .pgm_data   (pgm_data),
        .done       (done),
        .rdata      (rdata)
    );
endmodule

// File: rtl/secid_cmd_ctrl_chk.sv
module secid_cmd_ctrl_chk #(
    parameter int PROG_CYCLES = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] rdata,
    input logic        busy,
    input logic        query_mode,
    input logic        locked,
    input logic        pgm_go
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 16'd1;
        else           busy_run <= '0;
    end

    // R7: a busy window lasts exactly PROG_CYCLES cycles
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == 16'(PROG_CYCLES));

    // R8: status reads carry only bit 6
    p_status_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(busy)) |-> (rdata & 16'hFFBF) == 16'h0000);

    // R9: mode is frozen while a program runs
    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> query_mode == $past(query_mode));

    // R10: the lock never clears
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R10: once locked no program starts
    p_locked_no_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !pgm_go);
endmodule

bind secid_cmd_ctrl secid_cmd_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .busy       (busy),
    .query_mode (query_mode),
    .locked     (locked),
    .pgm_go     (pgm_go)
);

// File: tb/secid_cmd_ctrl_bench.sv
module secid_cmd_ctrl_bench;
    localparam int P = 20;
    localparam logic [127:0] FID = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    secid_cmd_ctrl #(.PROG_CYCLES(P), .FACTORY_ID(FID)) u_secid_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    // {req, is_read, addr, data, expected}
    typedef logic [52:0] vec_t;
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        {4'd3, 1'b1, 16'h0000, 16'h0000, 16'hFFFF},  // R3 normal mode reads FFFFh
        {4'd2, 1'b0, 16'h5555, 16'h00AA, 16'h0000},
        {4'd2, 1'b0, 16'h2AAA, 16'h0055, 16'h0000},
        {4'd2, 1'b0, 16'h5555, 16'h0088, 16'h0000},
        {4'd2, 1'b1, 16'h0000, 16'h0000, 16'h3210},  // R2 factory word 0
        {4'd2, 1'b1, 16'h0003, 16'h0000, 16'hFEDC},
        {4'd2, 1'b1, 16'h0007, 16'h0000, 16'h0123},
        {4'd3, 1'b1, 16'h0010, 16'h0000, 16'hFFFF},  // R3 user word blank
        {4'd3, 1'b1, 16'h0008, 16'h0000, 16'hFFFF},  // R3 gap offset
        {4'd3, 1'b1, 16'h0018, 16'h0000, 16'hFFFF},
        {4'd4, 1'b0, 16'h1234, 16'h00F0, 16'h0000},  // R4 single-write exit
        {4'd4, 1'b1, 16'h0000, 16'h0000, 16'hFFFF},
        {4'd5, 1'b0, 16'h5555, 16'h00AA, 16'h0000},  // R5 broken prefix
        {4'd5, 1'b0, 16'h1234, 16'h0055, 16'h0000},
        {4'd5, 1'b0, 16'h5555, 16'h0088, 16'h0000},
        {4'd5, 1'b1, 16'h0000, 16'h0000, 16'hFFFF},
        {4'd2, 1'b0, 16'h5555, 16'h00AA, 16'h0000},
        {4'd2, 1'b0, 16'h2AAA, 16'h0055, 16'h0000},
        {4'd2, 1'b0, 16'h5555, 16'h0088, 16'h0000},
        {4'd4, 1'b0, 16'h5555, 16'h00AA, 16'h0000},  // R4 prefixed exit
        {4'd4, 1'b0, 16'h2AAA, 16'h0055, 16'h0000},
        {4'd4, 1'b0, 16'h5555, 16'h00F0, 16'h0000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic cmd(input logic [7:0] op);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, {8'h00, op});
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 rdata", rdata, 16'hFFFF);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][48]) begin
                rd(VECS[i][47:32], v);
                check($sformatf("R%0d vector %0d", VECS[i][52:49], i), v, VECS[i][15:0]);
            end else begin
                wr(VECS[i][47:32], VECS[i][31:16]);
            end
        end
        rd(16'h0000, v);
        check("R4 prefixed exit", v, 16'hFFFF);

        // R6 R7 R8 R9: program user word 10h in query mode
        cmd(8'h88);
        cmd(8'hA5);
        wr(16'h0010, 16'h12F0);
        check("R7 busy rises", {15'd0, busy}, 16'd1);
        n = 1;
        rd(16'h0010, v);  n += 2;
        rd(16'h0010, v2); n += 2;
        check("R8 status mask", v & 16'hFFBF, 16'h0000);
        check("R8 alternation", v ^ v2, 16'h0040);
        wr(16'h0000, 16'h00F0); n += 2;   // R9 exit attempt while busy
        while (busy) begin
            @(negedge clk);
            if (busy) n++;
        end
        check("R7 busy length", 16'(n), 16'(P));
        rd(16'h0010, v);
        check("R6 program result", v, 16'h12F0);
        rd(16'h0002, v);
        check("R9 mode kept", v, 16'hBA98);

        // R6 AND behaviour
        cmd(8'hA5);
        wr(16'h0010, 16'hFF0F);
        wait_idle();
        rd(16'h0010, v);
        check("R6 bits only clear", v, 16'h1200);

        // R6 factory address rejected
        cmd(8'hA5);
        wr(16'h0002, 16'h0000);
        check("R6 factory no busy", {15'd0, busy}, 16'd0);
        rd(16'h0002, v);
        check("R6 factory unchanged", v, 16'hBA98);

        // R11 erase-style commands
        cmd(8'h80);
        cmd(8'h10);
        cmd(8'h80);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h0010, 16'h0030);
        rd(16'h0010, v);
        check("R11 user kept", v, 16'h1200);
        rd(16'h0000, v);
        check("R11 factory kept", v, 16'h3210);

        // R10 lock
        cmd(8'h85);
        cmd(8'hA5);
        wr(16'h0011, 16'h0000);
        check("R10 no busy", {15'd0, busy}, 16'd0);
        repeat (P + 2) @(negedge clk);
        rd(16'h0011, v);
        check("R10 word kept", v, 16'hFFFF);
        cmd(8'hA5);
        wr(16'h0010, 16'h0000);
        repeat (P + 2) @(negedge clk);
        rd(16'h0010, v);
        check("R10 programmed word kept", v, 16'h1200);

        // R1 reset restores normal mode
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(16'h0000, v);
        check("R1 normal after reset", v, 16'hFFFF);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule